// File: doc/BRIEF.md
# Three-Channel Interval Timer

This peripheral holds three independent up-counting timers behind one small register bus. Each channel chooses its count source: every system clock, or a shared synchronous strobe `alt_tick`. That source can be divided by a power of two before it reaches the counter. A channel either runs freely and wraps at its all-ones value, or runs in interval mode. In interval mode it returns to zero when it matches a programmed limit and flags an interval event.

Software sets up a channel through its clock-control, counter-control, interval and interrupt-enable registers. It reads the count at any time. It services an interrupt by reading the status register, which also clears the status. Each channel drives its own level interrupt line. Read data is combinational from the address, and a status read clears the flags at the clock edge that ends the read cycle.

Top module: `tri_timer`

## Requirements
- R1: Channel c (0..2) has its registers at byte offset base + 4*c, where the bases are: clock control 0x00, counter control 0x0C, count value 0x18 (read-only), interval 0x24, status 0x54 (read-only), interrupt enable 0x60. A read of any other offset returns zero, and a write to a read-only register changes nothing.
- R2: After reset every register reads zero except counter control, which reads 1 (the channel is stopped). All `irq` lines are low.
- R3: Clock control bit 5 selects the count source: 0 means every clock cycle, 1 means cycles with `alt_tick` high. Bit 0 enables division, and bits 4:1 hold N. With division on, the counter advances once every 2^(N+1) source pulses.
- R4: A counter-control write with bit 4 set zeroes the count and the divider at that clock edge. This overrides any tick in the same cycle, and bit 4 always reads back as 0.
- R5: While counter control bit 0 is 1, the count holds. Clearing the bit resumes counting from the held value.
- R6: With counter control bit 1 at 0, each tick adds one to the count. From all-ones (0xFFFF at 16 bits) the count goes to 0 and status bit 4 is set.
- R7: With counter control bit 1 at 1, a tick that finds the count equal to the interval sets the count to 0 and sets status bit 0. An interval of zero therefore flags on every tick. An interval written while the channel is stopped applies from the first tick after it resumes.
- R8: A status read returns the pending flags and clears them. A flag raised in the same cycle as the read is not in the returned value and stays pending.
- R9: `irq[c]` is high exactly when (status bit 0 AND enable bit 0) OR (status bit 4 AND enable bit 4) for channel c.
- R10: The counter width is a parameter that must be 16 or 32; any other value stops elaboration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write strobe for this cycle |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe for this cycle; clears status on a status read |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| alt_tick | input | 1 | Alternate count source, one pulse per enabled cycle |
| irq | output | 3 | Per-channel interrupt, level |

## Verification
Two things can fall in the same cycle: a status read clearing the flags and a new interval event setting one. The bench provokes this with a zero interval, which raises the interval flag on every tick, and then reads status back to back. The read must show the flag set before that edge, and the next read must still show the flag raised during the first. A counter reset write that lands on a tick is also covered, and the count must be zero afterwards with no event flagged. A behavioural model run alongside the design judges both cases on every clock through the interrupt lines and on every read.

// File: rtl/tri_timer_pkg.sv
package tri_timer_pkg;
   localparam int NUM_CH   = 3;
   localparam int CH_STEP  = 4;
   localparam int OFF_CLK  = 'h00;
   localparam int OFF_CTL  = 'h0C;
   localparam int OFF_VAL  = 'h18;
   localparam int OFF_IVL  = 'h24;
   localparam int OFF_STS  = 'h54;
   localparam int OFF_IEN  = 'h60;
   localparam int BUS_W    = 32;

   // bit 5 source select, bits 4:1 exponent, bit 0 divider enable
   typedef struct packed {
      logic       alt_src;
      logic [3:0] exp;
      logic       div_en;
   } clk_cfg_t;
endpackage

// File: rtl/tri_timer_presc.sv
module tri_timer_presc #(
   parameter int PRESC_W = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic       step,
   input  logic       div_en,
   input  logic [3:0] exp,
   output logic       tick
);
   localparam int MASK_W = PRESC_W + 1;

   if (PRESC_W < 16) begin : g_bad_presc
      $error("tri_timer_presc: PRESC_W must be at least 16");
   end

   logic [PRESC_W-1:0] pc_q;
   logic [MASK_W-1:0]  mask_full;
   logic [PRESC_W-1:0] mask;
   logic               full;

   always_comb begin
      mask_full = (MASK_W'(2) << exp) - MASK_W'(1);
      mask      = mask_full[PRESC_W-1:0];
      full      = (pc_q & mask) == mask;
      tick      = step & (div_en ? full : 1'b1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)              pc_q <= '0;
      else if (clr)            pc_q <= '0;
      else if (step && div_en) pc_q <= pc_q + PRESC_W'(1);
   end
endmodule

// File: rtl/tri_timer_chan.sv
module tri_timer_chan
   import tri_timer_pkg::*;
#(
   parameter int CNT_W   = 16,
   parameter int PRESC_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  clk_cfg_t         cfg,
   input  logic             stop,
   input  logic             ival_mode,
   input  logic             clr,
   input  logic [CNT_W-1:0] ival,
   input  logic             alt_tick,
   input  logic             sts_rd,
   output logic [CNT_W-1:0] count,
   output logic [1:0]       sts
);
   logic [CNT_W-1:0] cnt_q;
   logic [1:0]       sts_q;
   logic             step, tick, hit, wrap, set_int, set_ovf;

   assign step = ~stop & (cfg.alt_src ? alt_tick : 1'b1);

   tri_timer_presc #(.PRESC_W(PRESC_W)) u_presc (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (clr),
      .step   (step),
      .div_en (cfg.div_en),
      .exp    (cfg.exp),
      .tick   (tick)
   );

   always_comb begin
      hit     = ival_mode & (cnt_q == ival);
      wrap    = &cnt_q;
      set_int = tick & hit & ~clr;
      set_ovf = tick & ~hit & wrap & ~clr;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)           cnt_q <= '0;
      else if (clr)         cnt_q <= '0;
      else if (tick) begin
         if (hit || wrap)   cnt_q <= '0;
         else               cnt_q <= cnt_q + CNT_W'(1);
      end
   end

   // a flag raised in the read cycle survives the clear
   always_ff @(posedge clk) begin
      if (!rst_n) sts_q <= '0;
      else        sts_q <= (sts_rd ? 2'b00 : sts_q) | {set_ovf, set_int};
   end

   assign count = cnt_q;
   assign sts   = sts_q;
endmodule

// File: rtl/tri_timer.sv
module tri_timer
   import tri_timer_pkg::*;
#(
   parameter int CNT_W   = 16,
   parameter int ADDR_W  = 8,
   parameter int PRESC_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [31:0]       bus_wdata,
   input  logic              bus_rd,
   output logic [31:0]       bus_rdata,
   input  logic              alt_tick,
   output logic [2:0]        irq
);
   if (!(CNT_W == 16 || CNT_W == 32)) begin : g_bad_width
      $error("tri_timer: CNT_W must be 16 or 32");
   end
   if (ADDR_W < 7) begin : g_bad_addr
      $error("tri_timer: ADDR_W too narrow for the register map");
   end

   clk_cfg_t [NUM_CH-1:0]              cfg_a;
   logic     [NUM_CH-1:0]              stop_a, mode_a;
   logic     [NUM_CH-1:0][CNT_W-1:0]   ival_a, ch_count;
   logic     [NUM_CH-1:0][1:0]         ien_a, ch_sts;

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      localparam int ST = CH_STEP * ch;
      logic             w_clk, w_ctl, w_ivl, w_ien, clr, sts_rd;
      clk_cfg_t         cfg_q;
      logic             stop_q, mode_q;
      logic [CNT_W-1:0] ival_q;
      logic [1:0]       ien_q;

      always_comb begin
         w_clk  = bus_wr & (bus_addr == ADDR_W'(OFF_CLK + ST));
         w_ctl  = bus_wr & (bus_addr == ADDR_W'(OFF_CTL + ST));
         w_ivl  = bus_wr & (bus_addr == ADDR_W'(OFF_IVL + ST));
         w_ien  = bus_wr & (bus_addr == ADDR_W'(OFF_IEN + ST));
         clr    = w_ctl & bus_wdata[4];
         sts_rd = bus_rd & (bus_addr == ADDR_W'(OFF_STS + ST));
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            cfg_q  <= '0;
            stop_q <= 1'b1;
            mode_q <= 1'b0;
            ival_q <= '0;
            ien_q  <= '0;
         end else begin
            if (w_clk) cfg_q <= clk_cfg_t'(bus_wdata[5:0]);
            if (w_ctl) begin
               stop_q <= bus_wdata[0];
               mode_q <= bus_wdata[1];
            end
            if (w_ivl) ival_q <= bus_wdata[CNT_W-1:0];
            if (w_ien) ien_q  <= {bus_wdata[4], bus_wdata[0]};
         end
      end

      tri_timer_chan #(.CNT_W(CNT_W), .PRESC_W(PRESC_W)) u_chan (
         .clk       (clk),
         .rst_n     (rst_n),
         .cfg       (cfg_q),
         .stop      (stop_q),
         .ival_mode (mode_q),
         .clr       (clr),
         .ival      (ival_q),
         .alt_tick  (alt_tick),
         .sts_rd    (sts_rd),
         .count     (ch_count[ch]),
         .sts       (ch_sts[ch])
      );

      assign cfg_a[ch]  = cfg_q;
      assign stop_a[ch] = stop_q;
      assign mode_a[ch] = mode_q;
      assign ival_a[ch] = ival_q;
      assign ien_a[ch]  = ien_q;
      assign irq[ch]    = |(ch_sts[ch] & ien_q);
   end

   always_comb begin
      bus_rdata = '0;
      for (int ch = 0; ch < NUM_CH; ch++) begin
         if (bus_addr == ADDR_W'(OFF_CLK + CH_STEP*ch)) bus_rdata = {26'b0, cfg_a[ch]};
         if (bus_addr == ADDR_W'(OFF_CTL + CH_STEP*ch)) bus_rdata = {30'b0, mode_a[ch], stop_a[ch]};
         if (bus_addr == ADDR_W'(OFF_VAL + CH_STEP*ch)) bus_rdata = BUS_W'(ch_count[ch]);
         if (bus_addr == ADDR_W'(OFF_IVL + CH_STEP*ch)) bus_rdata = BUS_W'(ival_a[ch]);
         if (bus_addr == ADDR_W'(OFF_STS + CH_STEP*ch)) bus_rdata = {27'b0, ch_sts[ch][1], 3'b0, ch_sts[ch][0]};
         if (bus_addr == ADDR_W'(OFF_IEN + CH_STEP*ch)) bus_rdata = {27'b0, ien_a[ch][1], 3'b0, ien_a[ch][0]};
      end
   end
endmodule

// File: rtl/tri_timer_chk.sv
module tri_timer_chk
   import tri_timer_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int ADDR_W = 8
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic [ADDR_W-1:0]             bus_addr,
   input logic                          bus_wr,
   input logic [31:0]                   bus_wdata,
   input logic [2:0]                    irq,
   input logic [NUM_CH-1:0][CNT_W-1:0]  ch_count,
   input logic [NUM_CH-1:0][1:0]        ch_sts,
   input logic [NUM_CH-1:0][1:0]        ien_a,
   input logic [NUM_CH-1:0]             stop_a
);
   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chk
      logic clr_wr;
      assign clr_wr = bus_wr && bus_wdata[4] &&
                      (bus_addr == ADDR_W'(OFF_CTL + CH_STEP*ch));

      assert_clr_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
         clr_wr |=> (ch_count[ch] == '0));

      assert_stop_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (stop_a[ch] && !clr_wr) |=> $stable(ch_count[ch]));

      assert_count_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (ch_count[ch] != $past(ch_count[ch])) |->
            ((ch_count[ch] == $past(ch_count[ch]) + CNT_W'(1)) || (ch_count[ch] == '0)));

      assert_ival_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(ch_sts[ch][0]) |-> (ch_count[ch] == '0));

      assert_irq_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
         (ien_a[ch] == 2'b00) |-> !irq[ch]);
   end
endmodule

bind tri_timer tri_timer_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_wr    (bus_wr),
   .bus_wdata (bus_wdata),
   .irq       (irq),
   .ch_count  (ch_count),
   .ch_sts    (ch_sts),
   .ien_a     (ien_a),
   .stop_a    (stop_a)
);

// File: tb/tb_tri_timer.sv
module tb_tri_timer;
   localparam int CW   = 16;
   localparam int MAXV = 65535;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic        bus_rd = 1'b0;
   logic [31:0] bus_rdata;
   logic        alt_tick = 1'b0;
   logic [2:0]  irq;

   int n_tests = 0, n_fail = 0, cyc = 0;
   bit done = 0, alt_en = 0;

   // behavioural reference state
   int m_cfg[3], m_stop[3], m_mode[3], m_ival[3], m_ien[3], m_sts[3], m_cnt[3], m_pc[3];

   tri_timer #(.CNT_W(CW), .ADDR_W(8), .PRESC_W(16)) dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
      .alt_tick(alt_tick), .irq(irq));

   always #5 clk = ~clk;

   task automatic chk(string req, int act, int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int mread(int a);
      for (int ch = 0; ch < 3; ch++) begin
         if (a == 'h00 + 4*ch) return m_cfg[ch];
         if (a == 'h0C + 4*ch) return (m_mode[ch] << 1) | m_stop[ch];
         if (a == 'h18 + 4*ch) return m_cnt[ch];
         if (a == 'h24 + 4*ch) return m_ival[ch];
         if (a == 'h54 + 4*ch) return m_sts[ch];
         if (a == 'h60 + 4*ch) return m_ien[ch];
      end
      return 0;
   endfunction

   always @(posedge clk) begin
      cyc++;
      for (int ch = 0; ch < 3; ch++) begin
         int mask, set;
         bit clr, step, tick;
         if (!rst_n) begin
            m_cfg[ch] = 0; m_stop[ch] = 1; m_mode[ch] = 0; m_ival[ch] = 0;
            m_ien[ch] = 0; m_sts[ch] = 0; m_cnt[ch] = 0; m_pc[ch] = 0;
         end else begin
            clr  = bus_wr && (bus_addr == 'h0C + 4*ch) && bus_wdata[4];
            step = !m_stop[ch] && (((m_cfg[ch] >> 5) & 1) ? alt_tick : 1'b1);
            tick = 0; set = 0;
            if (clr) begin
               m_cnt[ch] = 0; m_pc[ch] = 0;
            end else begin
               if (step) begin
                  if (m_cfg[ch] & 1) begin
                     mask = (2 << ((m_cfg[ch] >> 1) & 15)) - 1;
                     tick = ((m_pc[ch] & mask) == mask);
                     m_pc[ch] = (m_pc[ch] + 1) & 65535;
                  end else tick = 1;
               end
               if (tick) begin
                  if (m_mode[ch] && m_cnt[ch] == m_ival[ch]) begin m_cnt[ch] = 0; set = 1; end
                  else if (m_cnt[ch] == MAXV) begin m_cnt[ch] = 0; set = 16; end
                  else m_cnt[ch]++;
               end
            end
            if (bus_rd && bus_addr == 'h54 + 4*ch) m_sts[ch] = 0;
            m_sts[ch] |= set;
            if (bus_wr) begin
               if (bus_addr == 'h00 + 4*ch) m_cfg[ch]  = bus_wdata & 63;
               if (bus_addr == 'h0C + 4*ch) begin m_stop[ch] = bus_wdata[0]; m_mode[ch] = bus_wdata[1]; end
               if (bus_addr == 'h24 + 4*ch) m_ival[ch] = bus_wdata & MAXV;
               if (bus_addr == 'h60 + 4*ch) m_ien[ch]  = bus_wdata & 17;
            end
         end
      end
   end

   // R9 and R2: interrupt lines compared with the model every cycle
   always @(negedge clk) begin
      if (!done) begin
         for (int ch = 0; ch < 3; ch++)
            chk("R9 irq", irq[ch], rst_n ? ((m_sts[ch] & m_ien[ch]) != 0) : 0);
         alt_tick <= alt_en && (cyc % 3 == 0);
      end
   end

   always @(posedge clk) begin
      if (cyc > 150000 && !done) begin
         done = 1;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=<150000", cyc);
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   task automatic rd(int a, string req);
      @(negedge clk);
      bus_addr = 8'(a); bus_rd = 1; bus_wr = 0;
      #1 chk(req, bus_rdata, mread(a));
   endtask

   task automatic wr(int a, int d);
      @(negedge clk);
      bus_addr = 8'(a); bus_wdata = d; bus_wr = 1; bus_rd = 0;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk) begin bus_wr = 0; bus_rd = 0; end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R2: reset values, counter control starts stopped
      for (int ch = 0; ch < 3; ch++)
         foreach (m_cfg[i]) begin
            int offs[6] = '{'h00, 'h0C, 'h18, 'h24, 'h54, 'h60};
            rd(offs[i] + 4*ch, "R2 reset value");
         end
      @(negedge clk); bus_addr = 8'h0C; bus_rd = 0;
      #1 chk("R2 ctl reads stopped", bus_rdata, 1);
      // R1: unmapped reads are zero, read-only writes ignored
      rd('h30, "R1 unmapped"); rd('h70, "R1 unmapped"); rd('hFC, "R1 unmapped");
      wr('h18, 'h1234); wr('h54, 'h11); idle(1);
      rd('h18, "R1 ro count"); rd('h54, "R1 ro status");
      // R7: interval mode on channel 0, R4 clear on start
      wr('h24, 5); wr('h60, 1); wr('h0C, 'h12); idle(20);
      rd('h18, "R7 count"); rd('h54, "R8 status read"); rd('h54, "R8 cleared");
      rd('h0C, "R4 bit4 reads 0");
      // R7: zero interval loaded while stopped
      wr('h0C, 'h03); wr('h24, 0); idle(3);
      rd('h18, "R5 held"); wr('h0C, 'h12); idle(4);
      // R8: clear and set in the same cycle
      rd('h54, "R8 same-cycle first"); rd('h54, "R8 same-cycle kept");
      // R5: stop and resume
      wr('h0C, 'h01); wr('h24, 9); wr('h0C, 'h10); idle(5);
      wr('h0C, 'h01); idle(2); rd('h18, "R5 stop"); idle(5); rd('h18, "R5 still");
      wr('h0C, 'h00); idle(4); rd('h18, "R5 resumed");
      // R4: clear while running
      wr('h0C, 'h10); rd('h18, "R4 clear");
      // R3: divide by 8 on channel 2
      wr('h08, 5); wr('h2C, 3); wr('h68, 1); wr('h14, 'h12); idle(60);
      rd('h20, "R3 div8 count"); rd('h5C, "R3 div8 status");
      // R3: alternate source, undivided then divided
      alt_en = 1;
      wr('h08, 'h20); idle(30); rd('h20, "R3 alt count");
      wr('h08, 'h25); wr('h14, 'h12); idle(80); rd('h20, "R3 alt div count");
      rd('h5C, "R3 alt status");
      alt_en = 0;
      // R6 and R10: 16-bit free run on channel 1 wraps at 0xFFFF
      wr('h0C, 'h01); wr('h14, 'h01);
      wr('h64, 'h10); wr('h10, 'h10); idle(65530);
      rd('h1C, "R6 near top"); idle(8);
      rd('h1C, "R10 wrapped at 16 bits"); rd('h58, "R6 overflow flag");
      rd('h58, "R6 overflow cleared");
      idle(3);
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule